// File: doc/BRIEF.md
# Debouncing Digital Time Filter

This block cleans up fault and command lines that come from a noisy high-voltage environment before they reach protection or control logic. Each asynchronous input line first passes through a two-flop synchroniser. It is then looked at only on a slow sampling strobe. The strobe comes from two cascaded clock dividers, which by default divide a 4 MHz clock by 256 and then by 256 again, giving a sample about every 16.4 ms. A channel's filtered output follows its input only after the input has disagreed with the output on more than a set number of strobes in a row. The default is more than eight, so nine samples.

The same rule applies in both directions. A filtered line sets only after a run of asserted samples, and it clears only after an equally long run of deasserted samples. Any sample that agrees with the current output restarts the run. Interference shorter than the confirmation window, and any pulse that falls between two strobes, never reaches the output. Fault inputs and command inputs go through identical channels. Logic downstream acts on a command only once its filtered level has changed. The divider lengths and the confirmation count are parameters, so the window can be made short for simulation.

Top module: `debounce_filter_bank`

## Requirements
- R1: Each raw input reaches the sampling point through exactly two flops. A level applied at least three clock edges before a sampling edge is taken by that sample. A level applied only two edges before it is taken by the next sample. A pulse lying wholly between two sampling edges is never sampled.
- R2: Sampling edges fall on every DIV_A*DIV_B-th clock edge after reset is released. The first is the DIV_A*DIV_B-th edge.
- R3: A filtered output takes the input's level on the sampling edge of the (CONFIRM+1)-th consecutive sample that disagrees with the output, and not earlier.
- R4: A single sample that agrees with the current output discards any partial run of disagreeing samples on that channel.
- R5: Clearing a filtered output follows the same rule as setting it, with the same count of consecutive deasserted samples.
- R6: Channels are independent. The input on one channel has no effect on the output of another.
- R7: While the synchronous reset is high, every filtered output is low, and all runs and divider counts restart from zero.
- R8: A filtered output changes only on a sampling edge and holds its value on every other clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4 MHz in the target system) |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | CHANNELS | Unsynchronised fault and command lines |
| clean_out | output | CHANNELS | Confirmed, debounced levels |

## Verification
The bench builds the block with three channels, DIV_A=4, DIV_B=2 and CONFIRM=3. A sample then falls every 8 clocks and four agreeing samples are needed. This makes every run length from one sample up to past the threshold cheap to sweep on every channel, in both directions, with channels given staggered lengths. The short period also lets the bench find the exact clock edge at which an output changes after reset, for inputs applied two and three edges before a strobe. It can also place single-clock glitches between strobes and interrupt partial runs, all in a few thousand cycles.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  // Bits needed to hold values 0..maxval.
  function automatic int width_for(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

  // "More than confirm" consecutive samples.
  function automatic int samples_needed(input int confirm);
    return confirm + 1;
  endfunction

  // Clocks between two sampling strobes.
  function automatic int strobe_period(input int div_a, input int div_b);
    return div_a * div_b;
  endfunction

endpackage

// File: rtl/dbf_divider.sv
module dbf_divider #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic wrap
);
  localparam int W = dbf_pkg::width_for(DIV - 1);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  assign wrap = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (en)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  a_r2_div_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  a_r7_div_reset: assert property (@(posedge clk)
    rst |=> cnt == '0);
endmodule

// File: rtl/dbf_strobe.sv
module dbf_strobe #(
  parameter int DIV_A = 256,
  parameter int DIV_B = 256
) (
  input  logic clk,
  input  logic rst,
  output logic strobe
);
  localparam int PERIOD = dbf_pkg::strobe_period(DIV_A, DIV_B);
  localparam int GW     = dbf_pkg::width_for(PERIOD);

  logic wrap_a;

  dbf_divider #(.DIV(DIV_A)) u_stage_a (
    .clk(clk), .rst(rst), .en(1'b1), .wrap(wrap_a));

  dbf_divider #(.DIV(DIV_B)) u_stage_b (
    .clk(clk), .rst(rst), .en(wrap_a), .wrap(strobe));

  // Independent gap counter used only to police strobe spacing.
  logic [GW-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst)         gap <= '0;
    else if (strobe) gap <= '0;
    else             gap <= gap + 1'b1;
  end

  a_r2_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
    strobe |-> gap == GW'(PERIOD - 1));

  a_r2_strobe_no_late: assert property (@(posedge clk) disable iff (rst)
    gap < GW'(PERIOD));
endmodule

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int CHANNELS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] d_async,
  output logic [CHANNELS-1:0] q
);
  logic [CHANNELS-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d_async;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dbf_channel.sv
module dbf_channel #(
  parameter int NEED = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic din,
  output logic q
);
  localparam int RW = dbf_pkg::width_for(NEED);

  logic [RW-1:0] run;
  logic          differs;
  logic          confirm;

  assign differs = (din != q);
  assign confirm = strobe && differs && (run == RW'(NEED - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0;
      q   <= 1'b0;
    end else if (strobe) begin
      if (!differs) begin
        run <= '0;
      end else if (confirm) begin
        q   <= din;
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  a_r8_hold_off_strobe: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(q));

  a_r3_run_bounded: assert property (@(posedge clk) disable iff (rst)
    run < RW'(NEED));

  a_r3_change_takes_sample: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> ($past(strobe) && $past(din) == q));

  a_r4_agree_clears: assert property (@(posedge clk) disable iff (rst)
    (strobe && !differs) |=> run == '0);

  a_r7_reset_low: assert property (@(posedge clk)
    rst |=> (q == 1'b0 && run == '0));
endmodule

// File: rtl/debounce_filter_bank.sv
module debounce_filter_bank #(
  parameter int CHANNELS = 4,
  parameter int DIV_A    = 256,
  parameter int DIV_B    = 256,
  parameter int CONFIRM  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] raw_in,
  output logic [CHANNELS-1:0] clean_out
);
  localparam int NEED = dbf_pkg::samples_needed(CONFIRM);

  logic                strobe;
  logic [CHANNELS-1:0] synced;

  dbf_strobe #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_strobe (
    .clk(clk), .rst(rst), .strobe(strobe));

  dbf_sync #(.CHANNELS(CHANNELS)) u_sync (
    .clk(clk), .rst(rst), .d_async(raw_in), .q(synced));

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    dbf_channel #(.NEED(NEED)) u_chan (
      .clk(clk), .rst(rst), .strobe(strobe),
      .din(synced[c]), .q(clean_out[c]));
  end

  a_r7_outputs_low: assert property (@(posedge clk)
    rst |=> clean_out == '0);
endmodule

// File: tb/sim_debounce_filter_bank.sv
`timescale 1ns/1ps
module sim_debounce_filter_bank;
  localparam int CH   = 3;
  localparam int DA   = 4;
  localparam int DB   = 2;
  localparam int CF   = 3;
  localparam int P    = DA * DB;
  localparam int NEED = CF + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CH-1:0] raw = '0;
  logic [CH-1:0] out;

  int total = 0;
  int bad   = 0;
  int ncyc  = 0;

  int            run_m [CH];
  logic [CH-1:0] exp_q = '0;

  debounce_filter_bank #(.CHANNELS(CH), .DIV_A(DA), .DIV_B(DB), .CONFIRM(CF)) u0 (
    .clk(clk), .rst(rst), .raw_in(raw), .clean_out(out));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ncyc <= 0;
    else     ncyc <= ncyc + 1;
  end

  task automatic check(input string req, input logic [CH-1:0] act, input logic [CH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, ncyc, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < CH; c++) run_m[c] = 0;
    exp_q = '0;
  endtask

  // One sample per channel: count consecutive disagreements.
  task automatic model_sample(input logic [CH-1:0] v);
    for (int c = 0; c < CH; c++) begin
      if (v[c] != exp_q[c]) begin
        run_m[c] = run_m[c] + 1;
        if (run_m[c] == NEED) begin
          exp_q[c] = v[c];
          run_m[c] = 0;
        end
      end else begin
        run_m[c] = 0;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    raw = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 reset state", out, '0);
    rst = 1'b0;
    model_reset();
  endtask

  // One sampling interval: apply v mid-interval (optionally after a
  // one-clock inverted glitch), check just before and just after the sample.
  task automatic interval(input logic [CH-1:0] v, input bit glitch, input string req);
    while (ncyc % P != P / 2) @(negedge clk);
    if (glitch) begin
      raw = ~v;
      @(negedge clk);
    end
    raw = v;
    while (ncyc % P != P - 1) @(negedge clk);
    check("R8 hold before sampling edge", out, exp_q);
    @(negedge clk);
    model_sample(v);
    check(req, out, exp_q);
  endtask

  // Latency from a raw edge placed at a given offset after reset.
  task automatic latency(input int offset, input int exp_edge, input string req);
    do_reset();
    while (ncyc != offset) @(negedge clk);
    raw = '1;
    while (out !== '1 && ncyc < 4 * NEED * P) begin
      @(negedge clk);
      if (out !== '0 && out !== '1) break;
    end
    check_int(req, ncyc, exp_edge);
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog expired at cycle %0d", ncyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();

    // R1/R2: exact edge of first rise.
    latency(P - 3, NEED * P,       "R2 R1 first rise, raw three edges before strobe");
    latency(P - 2, (NEED + 1) * P, "R1 raw two edges before strobe misses sample");

    // R3/R5/R6: sweep run lengths, channels staggered by one sample.
    for (int len = 1; len <= NEED + 1; len++) begin
      do_reset();
      for (int i = 0; i < len + CH - 1; i++) begin
        logic [CH-1:0] v;
        for (int c = 0; c < CH; c++) v[c] = (i < len + c);
        interval(v, 1'b0, "R3 R6 assert run");
      end
      for (int i = 0; i < NEED + 1; i++) interval('0, 1'b0, "R5 release run");
    end

    // R4: interrupted runs in both directions.
    do_reset();
    interval('1, 1'b0, "R4 set run");
    interval('1, 1'b0, "R4 set run");
    interval('1, 1'b0, "R4 set run");
    interval('0, 1'b0, "R4 agreeing sample clears");
    for (int i = 0; i < NEED; i++) interval('1, 1'b0, "R4 fresh set run");
    check("R3 set after full run", out, '1);
    interval('0, 1'b0, "R4 clear run");
    interval('0, 1'b0, "R4 clear run");
    interval('1, 1'b0, "R4 agreeing sample clears");
    for (int i = 0; i < NEED; i++) interval('0, 1'b0, "R5 fresh clear run");
    check("R5 cleared after full run", out, '0);

    // R1: one-clock glitches between strobes are never sampled.
    for (int i = 0; i < 2 * NEED; i++) interval('0, 1'b1, "R1 inter-strobe glitch ignored");
    check("R1 no output from glitches", out, '0);

    // R6: one channel active, others quiet.
    for (int c = 0; c < CH; c++) begin
      do_reset();
      for (int i = 0; i < NEED; i++) interval(CH'(1) << c, 1'b0, "R6 single channel");
      check("R6 only active channel set", out, CH'(1) << c);
    end

    // R7: reset in the middle of confirmed state.
    do_reset();
    for (int i = 0; i < NEED; i++) interval('1, 1'b0, "R3 before reset");
    do_reset();
    interval('1, 1'b0, "R7 run restarted after reset");
    check("R7 output still low one sample after reset", out, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule